// File: doc/BRIEF.md
# Transmit Power-Up Sequencing Controller

This block orders the enable lines of a pulsed RF transmit chain. A transmit request moves it from rest through a bias phase, a supply and switch phase, an unmuted pulse with envelope ramp-up, a ramp-down, and a staged return to rest. On the way up, bias comes first and the power-amplifier supply second. On the way down, the envelope falls first, then RF is muted, then the switch goes back to receive, then the supply is removed, and bias is removed last.

Three settle windows are cycle counts taken from input ports: how long bias-ready must stay high, how long the switch must sit in transmit before RF is released, and how long receiver blanking is held after the switch leaves transmit. A fault, or a loss of bias-ready while the supply is on, mutes RF in the same cycle. It then forces the chain off, holds blanking for the recovery window and latches. Only a qualified clear releases the latch, and the machine then returns to rest.

Top module: `tx_seq_ctrl`

## Requirements
- R1: While reset is low and right after it, rf_mute is 1 and sw_tx, rx_blank, bias_en, supply_en and fault_latched are 0.
- R2: At rest, tx_req has no effect while interlock_ok is 0, and bias_en stays 0. With interlock_ok at 1, a tx_req sampled at a clock edge sets bias_en at that edge while supply_en stays 0.
- R3: supply_en rises at the first edge at which bias_ready has been sampled high on stable_len earlier consecutive edges, is still high, and supply_ok is 1. A low sample of bias_ready restarts the count. With supply_ok at 0, supply_en stays 0. supply_en is never 1 without bias_en.
- R4: sw_tx and rx_blank rise at the same edge as supply_en. rf_mute falls settle_len+1 edges later. ramp_up is 1 for exactly the first cycle in which rf_mute is 0.
- R5: A pulse_end sample sets ramp_down, and rf_mute stays 0 until ramp_done is sampled. At that edge rf_mute rises while sw_tx is still 1. sw_tx falls one edge later.
- R6: After sw_tx falls, rx_blank stays 1 for recover_len+1 cycles. supply_en falls when rx_blank falls, and bias_en falls one cycle after that.
- R7: fault_in at 1 forces rf_mute to 1 within the same cycle. At the next edge fault_latched rises, and sw_tx, bias_en and supply_en go to 0. rx_blank is then 1 for recover_len+1 cycles counted from the rise of fault_latched.
- R8: fault_latched stays 1 until fault_clear is sampled with fault_in at 0 and interlock_ok at 1, after the blanking window has ended. A clear given earlier, or under other conditions, is ignored. After the clear the machine is at rest: bias_en is 0 and rf_mute is 1.
- R9: bias_ready at 0 while supply_en is 1 is a fault: rf_mute is 1 in that cycle and fault_latched rises at the next edge.
- R10: rf_mute is 0 only while sw_tx, supply_en and bias_en are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_req | input | 1 | Request to start a transmit sequence |
| interlock_ok | input | 1 | Safety interlocks are valid |
| bias_ready | input | 1 | PA bias reported settled |
| supply_ok | input | 1 | Supply bus inside its window |
| pulse_end | input | 1 | Request to end the RF pulse |
| ramp_done | input | 1 | Envelope ramp-down has finished |
| fault_in | input | 1 | Fault from protection logic |
| fault_clear | input | 1 | Request to release the fault latch |
| stable_len | input | CNT_W | Consecutive bias-ready cycles required |
| settle_len | input | CNT_W | Switch settle cycles before unmute |
| recover_len | input | CNT_W | Blanking recovery cycles after switch-back |
| bias_en | output | 1 | PA bias enable |
| supply_en | output | 1 | PA supply enable |
| sw_tx | output | 1 | T/R switch to transmit (0 = receive-safe) |
| rx_blank | output | 1 | Receiver blanking |
| rf_mute | output | 1 | RF gate closed |
| ramp_up | output | 1 | One-cycle envelope ramp-up start |
| ramp_down | output | 1 | Envelope ramp-down command |
| fault_latched | output | 1 | Latched fault indication |

## Verification
The bench builds the block with CNT_W at 8 and drives stable_len, settle_len and recover_len as 3, 4 and 5. Because the three values differ and are small, an off-by-one or a swapped window shows up as a wrong count on a specific output edge, and every window closes within a few cycles. A fault, a bias drop and latch-release attempts can therefore be placed in each phase of a pulse inside a short run.

// File: rtl/tx_seq_ctrl.sv
module tx_seq_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_req,
  input  logic             interlock_ok,
  input  logic             bias_ready,
  input  logic             supply_ok,
  input  logic             pulse_end,
  input  logic             ramp_done,
  input  logic             fault_in,
  input  logic             fault_clear,
  input  logic [CNT_W-1:0] stable_len,
  input  logic [CNT_W-1:0] settle_len,
  input  logic [CNT_W-1:0] recover_len,
  output logic             bias_en,
  output logic             supply_en,
  output logic             sw_tx,
  output logic             rx_blank,
  output logic             rf_mute,
  output logic             ramp_up,
  output logic             ramp_down,
  output logic             fault_latched
);

  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] ONE  = 1;

  typedef enum logic [3:0] {
    S_IDLE, S_PREBIAS, S_TXRDY, S_RFON, S_RAMPDN,
    S_MUTE, S_RECOV, S_SUPOFF, S_FHOLD, S_FLATCH
  } st_t;

  st_t st, nx;
  logic [CNT_W-1:0] cnt, stab;
  logic live, bias_lost, trip;

  assign live      = st inside {S_TXRDY, S_RFON, S_RAMPDN, S_MUTE, S_RECOV};
  assign bias_lost = live && !bias_ready;
  assign trip      = (fault_in || bias_lost) && !(st inside {S_FHOLD, S_FLATCH});

  always_comb begin
    nx = st;
    case (st)
      S_IDLE:    if (tx_req && interlock_ok) nx = S_PREBIAS;
      S_PREBIAS: if (bias_ready && stab >= stable_len && supply_ok) nx = S_TXRDY;
      S_TXRDY:   if (cnt >= settle_len) nx = S_RFON;
      S_RFON:    if (pulse_end) nx = S_RAMPDN;
      S_RAMPDN:  if (ramp_done) nx = S_MUTE;
      S_MUTE:    nx = S_RECOV;
      S_RECOV:   if (cnt >= recover_len) nx = S_SUPOFF;
      S_SUPOFF:  nx = S_IDLE;
      S_FHOLD:   if (cnt >= recover_len) nx = S_FLATCH;
      S_FLATCH:  if (fault_clear && !fault_in && interlock_ok) nx = S_IDLE;
      default:   nx = S_IDLE;
    endcase
    if (trip) nx = S_FHOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      stab <= '0;
    end else begin
      st   <= nx;
      cnt  <= (nx != st) ? '0 : ((cnt == CMAX) ? cnt : cnt + ONE);
      stab <= (st == S_PREBIAS && bias_ready) ? ((stab == CMAX) ? stab : stab + ONE) : '0;
    end
  end

  assign bias_en       = st inside {S_PREBIAS, S_TXRDY, S_RFON, S_RAMPDN, S_MUTE, S_RECOV, S_SUPOFF};
  assign supply_en     = st inside {S_TXRDY, S_RFON, S_RAMPDN, S_MUTE, S_RECOV};
  assign sw_tx         = st inside {S_TXRDY, S_RFON, S_RAMPDN, S_MUTE};
  assign rx_blank      = st inside {S_TXRDY, S_RFON, S_RAMPDN, S_MUTE, S_RECOV, S_FHOLD};
  assign rf_mute       = !(st inside {S_RFON, S_RAMPDN}) || fault_in || bias_lost;
  assign ramp_up       = (st == S_RFON) && (cnt == '0);
  assign ramp_down     = (st == S_RAMPDN);
  assign fault_latched = st inside {S_FHOLD, S_FLATCH};

  assert_no_req_without_interlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bias_en && !fault_latched && !interlock_ok) |=> !bias_en);

  assert_supply_needs_bias_R3: assert property (@(posedge clk) disable iff (!rst_n)
    supply_en |-> bias_en);

  assert_switch_back_after_mute_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_tx) |-> $past(rf_mute));

  assert_supply_off_before_bias_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bias_en) && !fault_latched |-> $past(!supply_en));

  assert_fault_latches_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_in && !fault_latched) |=> (fault_latched && !sw_tx && !supply_en));

  assert_latch_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && !fault_clear) |=> fault_latched);

  assert_rf_needs_path_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rf_mute |-> (sw_tx && supply_en && bias_en));

endmodule

// File: tb/tb_tx_seq_ctrl.sv
module tb_tx_seq_ctrl;
  localparam int W   = 8;
  localparam int STB = 3;
  localparam int SET = 4;
  localparam int REC = 5;

  logic clk = 0, rst_n = 0;
  logic tx_req = 0, interlock_ok = 0, bias_ready = 0, supply_ok = 0;
  logic pulse_end = 0, ramp_done = 0, fault_in = 0, fault_clear = 0;
  logic [W-1:0] stable_len = STB[W-1:0], settle_len = SET[W-1:0], recover_len = REC[W-1:0];
  logic bias_en, supply_en, sw_tx, rx_blank, rf_mute, ramp_up, ramp_down, fault_latched;
  int nchk = 0, nbad = 0;

  always #10 clk = ~clk;

  tx_seq_ctrl #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .interlock_ok(interlock_ok),
    .bias_ready(bias_ready), .supply_ok(supply_ok), .pulse_end(pulse_end),
    .ramp_done(ramp_done), .fault_in(fault_in), .fault_clear(fault_clear),
    .stable_len(stable_len), .settle_len(settle_len), .recover_len(recover_len),
    .bias_en(bias_en), .supply_en(supply_en), .sw_tx(sw_tx), .rx_blank(rx_blank),
    .rf_mute(rf_mute), .ramp_up(ramp_up), .ramp_down(ramp_down),
    .fault_latched(fault_latched));

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic start_req();
    interlock_ok = 1; tx_req = 1; step(); tx_req = 0;
  endtask

  task automatic go_rf_on();
    start_req(); supply_ok = 1; bias_ready = 1;
    for (int i = 0; i < 40 && rf_mute; i++) step();
  endtask

  task automatic t_reset();
    rst_n = 0; step(); step();
    chk("R1 mute in reset", rf_mute, 1);
    chk("R1 sw_tx in reset", sw_tx, 0);
    chk("R1 blank in reset", rx_blank, 0);
    chk("R1 bias in reset", bias_en, 0);
    rst_n = 1; step();
    chk("R1 mute after reset", rf_mute, 1);
    chk("R1 supply after reset", supply_en, 0);
    chk("R1 latch after reset", fault_latched, 0);
  endtask

  task automatic t_ignore_req();
    interlock_ok = 0; tx_req = 1;
    for (int i = 0; i < 3; i++) step();
    tx_req = 0;
    chk("R2 req ignored without interlock", bias_en, 0);
  endtask

  task automatic t_normal_pulse();
    int n;
    supply_ok = 1;
    start_req();
    chk("R2 bias on request", bias_en, 1);
    chk("R2 supply waits", supply_en, 0);
    bias_ready = 1; n = 0;
    for (int i = 0; i < 40; i++) begin step(); n++; if (supply_en) break; end
    chk("R3 stable count", n, STB + 1);
    chk("R4 switch with supply", sw_tx, 1);
    chk("R4 blank with switch", rx_blank, 1);
    chk("R4 muted during settle", rf_mute, 1);
    n = 0;
    for (int i = 0; i < 40; i++) begin step(); n++; if (!rf_mute) break; end
    chk("R4 settle count", n, SET + 1);
    chk("R4 ramp_up pulse", ramp_up, 1);
    step();
    chk("R4 ramp_up one cycle", ramp_up, 0);
    pulse_end = 1; step(); pulse_end = 0;
    chk("R5 ramp_down on end", ramp_down, 1);
    chk("R5 RF live during ramp", rf_mute, 0);
    step(); step();
    chk("R5 waits for ramp_done", ramp_down, 1);
    ramp_done = 1; step(); ramp_done = 0;
    chk("R5 mute after ramp", rf_mute, 1);
    chk("R5 switch still TX at mute", sw_tx, 1);
    step();
    chk("R5 switch back to RX", sw_tx, 0);
    chk("R6 blank held", rx_blank, 1);
    chk("R6 supply held during recovery", supply_en, 1);
    n = 1;
    for (int i = 0; i < 40; i++) begin step(); if (!rx_blank) break; n++; end
    chk("R6 recovery count", n, REC + 1);
    chk("R6 supply off with blank", supply_en, 0);
    chk("R6 bias still on", bias_en, 1);
    step();
    chk("R6 bias off last", bias_en, 0);
    bias_ready = 0;
  endtask

  task automatic t_supply_window();
    int n;
    supply_ok = 1;
    start_req();
    bias_ready = 1; step(); step();
    bias_ready = 0; step();
    bias_ready = 1; n = 0;
    for (int i = 0; i < 40; i++) begin step(); n++; if (supply_en) break; end
    chk("R3 glitch restarts count", n, STB + 1);
    fault_in = 1; step(); fault_in = 0;
    for (int i = 0; i < REC + 2; i++) step();
    fault_clear = 1; step(); fault_clear = 0;
    chk("R8 cleared", fault_latched, 0);
    supply_ok = 0;
    start_req();
    for (int i = 0; i < STB + 4; i++) step();
    chk("R3 supply blocked by window", supply_en, 0);
    supply_ok = 1; step();
    chk("R3 supply on once in window", supply_en, 1);
    fault_in = 1; step(); fault_in = 0;
    chk("R7 fault in settle latches", fault_latched, 1);
    for (int i = 0; i < REC + 2; i++) step();
    fault_clear = 1; step(); fault_clear = 0;
    bias_ready = 0;
  endtask

  task automatic t_fault_rules();
    int n;
    go_rf_on();
    chk("R4 reached RF on", rf_mute, 0);
    fault_in = 1; #1;
    chk("R7 mute same cycle", rf_mute, 1);
    step();
    chk("R7 latch next edge", fault_latched, 1);
    chk("R7 switch to RX", sw_tx, 0);
    chk("R7 bias off", bias_en, 0);
    chk("R7 supply off", supply_en, 0);
    chk("R7 blank on", rx_blank, 1);
    fault_in = 0; fault_clear = 1; n = 1;
    for (int i = 0; i < 40; i++) begin step(); if (!rx_blank) break; n++; end
    fault_clear = 0;
    chk("R7 fault recovery count", n, REC + 1);
    chk("R8 clear during hold ignored", fault_latched, 1);
    for (int i = 0; i < 4; i++) step();
    chk("R8 latch holds", fault_latched, 1);
    fault_in = 1; fault_clear = 1; step();
    chk("R8 clear with fault high ignored", fault_latched, 1);
    fault_in = 0; interlock_ok = 0; step();
    chk("R8 clear without interlock ignored", fault_latched, 1);
    interlock_ok = 1; step(); fault_clear = 0;
    chk("R8 clear accepted", fault_latched, 0);
    chk("R8 rest bias off", bias_en, 0);
    chk("R8 rest muted", rf_mute, 1);
    start_req();
    chk("R8 restart via bias phase", bias_en, 1);
    chk("R8 restart supply off", supply_en, 0);
    chk("R8 restart still muted", rf_mute, 1);
    bias_ready = 1;
    for (int i = 0; i < 40 && rf_mute; i++) step();
    bias_ready = 0; #1;
    chk("R9 bias drop mutes", rf_mute, 1);
    step();
    chk("R9 bias drop latches", fault_latched, 1);
    for (int i = 0; i < REC + 2; i++) step();
    fault_clear = 1; step(); fault_clear = 0;
    chk("R9 cleared after drop", fault_latched, 0);
  endtask

  initial begin
    #(20 * 150000);
    nbad++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk + 1, nbad);
    $finish;
  end

  initial begin
    t_reset();
    t_ignore_req();
    t_normal_pulse();
    t_supply_window();
    t_fault_rules();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end
endmodule